// File: doc/BRIEF.md
# Interleaved Hard-Decision Viterbi Decoder

This block decodes a rate-1/2 convolutional code whose transmitter runs several independent encoders and sends their symbols in turn, one symbol per stream, round robin. The receiver hands the decoder one hard-decision bit pair per clock, marked by a valid strobe. Symbol n belongs to stream n mod I, where I is the interleave degree. The decoder returns one decoded bit per accepted symbol, in the same stream order, with its own valid strobe.

The code has constraint length 3 and generators 7 and 5 (octal), which gives four trellis states. There is one add-compare-select unit for each state. The survivors are kept by register exchange: each state holds a row of decided bits that is copied and extended at every step. Each path-metric register and each survivor row is a chain of I registers instead of a single register. Because of this, the value an ACS unit reads is the one its own stream wrote I accepted symbols earlier. One set of ACS units therefore serves all I streams at the full clock rate, and no deinterleaver is needed around it.

Top module: `viterbiInterleaved`

## Requirements
- R1: A synchronous reset sets, for every interleave slot, the state-0 path metric to 0 and the other metrics to 2^(METRIC_W-2). It clears every survivor row and the fill count, and drives `outValid` low on the cycle after reset. After a reset during traffic, the output waits through the full fill again.
- R2: `inSym[0]` is the received bit of generator 7 (u xor s1 xor s2) and `inSym[1]` is that of generator 5 (u xor s2). Here s1 and s2 are the previous two inputs of that stream, and every encoder starts at zero. For error-free input, the output register after accepting symbol n holds the information bit of symbol n-(DEPTH-1)*I.
- R3: Path metrics are unsigned. When the freshly computed metrics of a slot all have their MSB set, the smallest of them is subtracted from each one. No metric wraps, and decoding stays correct after an arbitrarily long run of random input.
- R4: Streams are fully independent. Symbol n updates only the metrics and survivors of stream n mod I, and decoded bits leave in the input's stream order.
- R5: Once primed, every accepted symbol produces exactly one output with `outValid` high on the next cycle. A run of N symbols yields N-(DEPTH-1)*I outputs.
- R6: `outValid` stays low for the first (DEPTH-1)*I accepted symbols after reset.
- R7: A cycle with `inValid` low changes no metric or survivor, and `outValid` is low on the following cycle.
- R8: A single flipped received bit in a stream is corrected when flips in that stream are at least 30 steps apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A received symbol is present on `inSym` |
| inSym | input | 2 | Hard-decision pair: bit 0 for generator 7, bit 1 for generator 5 |
| outValid | output | 1 | `outBit` carries a decoded bit this cycle |
| outBit | output | 1 | Decoded information bit, in interleaved stream order |

## Verification
The case hardest to reach from the ports is metric normalization. With clean or lightly corrupted input the correct path keeps a metric near zero, so the condition where every metric's MSB is set never comes up. The stimulus therefore first feeds several hundred random symbols, which drives every stream's metrics up past half range more than once. It then switches to a freshly encoded clean stream and checks that the decoded bits match once the survivors have settled. A wrapped or missing normalization would make the decoder choose wrong paths there.

// File: rtl/vitPkg.sv
package vitPkg;

  // Trellis shape for the constraint-length-3 code.
  localparam int STATE_BITS = 2;
  localparam int NUM_STATES = 1 << STATE_BITS;

  // Generator taps, newest input in the MSB.
  localparam logic [STATE_BITS:0] GEN_A = 3'b111;
  localparam logic [STATE_BITS:0] GEN_B = 3'b101;

  // Strobes from control to datapath.
  typedef struct packed {
    logic shift;   // accept the symbol: advance all chains
    logic emit;    // the emitted bit is a real decision
  } vitStrobes_t;

  // Hamming distance between a received pair and the label of the branch
  // that leaves predecessor state pred on input bit u.
  function automatic logic [1:0] branchDist(
    input logic [STATE_BITS-1:0] pred,
    input logic                  u,
    input logic [1:0]            rx
  );
    logic [STATE_BITS:0] reg3;
    logic codeA;
    logic codeB;
    reg3  = {u, pred};
    codeA = ^(reg3 & GEN_A);
    codeB = ^(reg3 & GEN_B);
    return 2'(rx[0] ^ codeA) + 2'(rx[1] ^ codeB);
  endfunction

endpackage

// File: rtl/vitAcs.sv
module vitAcs #(
  parameter int METRIC_W = 6
) (
  input  logic [METRIC_W-1:0] metricLo,
  input  logic [METRIC_W-1:0] metricHi,
  input  logic [1:0]          distLo,
  input  logic [1:0]          distHi,
  output logic [METRIC_W-1:0] sumOut,
  output logic                pickHi
);

  logic [METRIC_W-1:0] sumLo;
  logic [METRIC_W-1:0] sumHi;

  always_comb begin
    sumLo  = metricLo + METRIC_W'(distLo);
    sumHi  = metricHi + METRIC_W'(distHi);
    // Strict compare: equal sums keep the lower-indexed predecessor.
    pickHi = (sumHi < sumLo);
    sumOut = pickHi ? sumHi : sumLo;
  end

endmodule

// File: rtl/vitCtrl.sv
module vitCtrl
  import vitPkg::*;
#(
  parameter int FILL_COUNT = 56
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output vitStrobes_t strobes
);

  localparam int CNT_W = $clog2(FILL_COUNT + 1);

  logic [CNT_W-1:0] acceptCount;
  logic             primed;

  assign primed = (acceptCount == CNT_W'(FILL_COUNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      acceptCount <= '0;
    end else if (inValid && !primed) begin
      acceptCount <= acceptCount + 1'b1;
    end
  end

  always_comb begin
    strobes.shift = inValid;
    strobes.emit  = inValid && primed;
  end

endmodule

// File: rtl/vitDatapath.sv
module vitDatapath
  import vitPkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int DEPTH       = 15,
  parameter int METRIC_W    = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  vitStrobes_t                    strobes,
  input  logic [1:0]                     inSym,
  output logic                           outValid,
  output logic                           outBit,
  output logic [NUM_STATES*METRIC_W-1:0] headMetricFlat
);

  localparam int                  HALF      = NUM_STATES / 2;
  localparam int                  TAIL      = NUM_STREAMS - 1;
  localparam logic [METRIC_W-1:0] INIT_COST = METRIC_W'(1) << (METRIC_W - 2);

  // Stage 0 is written by the ACS array; stage TAIL feeds it back.
  logic [NUM_STATES-1:0][METRIC_W-1:0] metricChain [NUM_STREAMS];
  logic [NUM_STATES-1:0][DEPTH-1:0]    survChain   [NUM_STREAMS];

  logic [NUM_STATES-1:0][METRIC_W-1:0] sumVec;
  logic [NUM_STATES-1:0][METRIC_W-1:0] nextMetric;
  logic [NUM_STATES-1:0][DEPTH-1:0]    newRow;
  logic [NUM_STATES-1:0]               pickHi;

  // One ACS unit per state.
  for (genvar ns = 0; ns < NUM_STATES; ns++) begin : gState
    localparam logic [STATE_BITS-1:0] PRED_LO = STATE_BITS'((ns % HALF) * 2);
    localparam logic [STATE_BITS-1:0] PRED_HI = STATE_BITS'((ns % HALF) * 2 + 1);
    localparam logic                  IN_BIT  = 1'(ns / HALF);

    logic [1:0] distLo;
    logic [1:0] distHi;

    assign distLo = branchDist(PRED_LO, IN_BIT, inSym);
    assign distHi = branchDist(PRED_HI, IN_BIT, inSym);

    vitAcs #(.METRIC_W(METRIC_W)) uAcs (
      .metricLo (metricChain[TAIL][PRED_LO]),
      .metricHi (metricChain[TAIL][PRED_HI]),
      .distLo   (distLo),
      .distHi   (distHi),
      .sumOut   (sumVec[ns]),
      .pickHi   (pickHi[ns])
    );

    // Register exchange: copy the winner's row, newest decision at the LSB.
    assign newRow[ns] = pickHi[ns]
      ? {survChain[TAIL][PRED_HI][DEPTH-2:0], IN_BIT}
      : {survChain[TAIL][PRED_LO][DEPTH-2:0], IN_BIT};
  end

  // Normalization once every new metric reaches the upper half of its range.
  always_comb begin
    logic [METRIC_W-1:0] minSum;
    logic                allHigh;
    minSum  = sumVec[0];
    allHigh = 1'b1;
    for (int s = 0; s < NUM_STATES; s++) begin
      if (sumVec[s] < minSum) minSum = sumVec[s];
      allHigh = allHigh & sumVec[s][METRIC_W-1];
    end
    for (int s = 0; s < NUM_STATES; s++) begin
      nextMetric[s] = allHigh ? (sumVec[s] - minSum) : sumVec[s];
    end
  end

  // Interleave chains: I delays per metric register and per survivor row.
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gStage
    if (g == 0) begin : gHead
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < NUM_STATES; s++) begin
            metricChain[g][s] <= (s == 0) ? '0 : INIT_COST;
            survChain[g][s]   <= '0;
          end
        end else if (strobes.shift) begin
          metricChain[g] <= nextMetric;
          survChain[g]   <= newRow;
        end
      end
    end else begin : gBody
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < NUM_STATES; s++) begin
            metricChain[g][s] <= (s == 0) ? '0 : INIT_COST;
            survChain[g][s]   <= '0;
          end
        end else if (strobes.shift) begin
          metricChain[g] <= metricChain[g-1];
          survChain[g]   <= survChain[g-1];
        end
      end
    end
  end

  // Oldest decision of the state-0 row.
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outBit   <= 1'b0;
    end else begin
      outValid <= strobes.emit;
      if (strobes.shift) outBit <= newRow[0][DEPTH-1];
    end
  end

  assign headMetricFlat = metricChain[0];

endmodule

// File: rtl/viterbiInterleaved.sv
module viterbiInterleaved
  import vitPkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int DEPTH       = 15,
  parameter int METRIC_W    = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [1:0] inSym,
  output logic       outValid,
  output logic       outBit
);

  localparam int FILL_COUNT = (DEPTH - 1) * NUM_STREAMS;

  vitStrobes_t                    strobes;
  logic [NUM_STATES*METRIC_W-1:0] headMetricFlat;

  vitCtrl #(.FILL_COUNT(FILL_COUNT)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes)
  );

  vitDatapath #(
    .NUM_STREAMS (NUM_STREAMS),
    .DEPTH       (DEPTH),
    .METRIC_W    (METRIC_W)
  ) uDatapath (
    .clk            (clk),
    .rst            (rst),
    .strobes        (strobes),
    .inSym          (inSym),
    .outValid       (outValid),
    .outBit         (outBit),
    .headMetricFlat (headMetricFlat)
  );

endmodule

// File: rtl/vitChecker.sv
module vitChecker #(
  parameter int NUM_STREAMS = 4,
  parameter int DEPTH       = 15,
  parameter int METRIC_W    = 6,
  parameter int NUM_STATES  = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           inValid,
  input logic                           outValid,
  input logic [NUM_STATES*METRIC_W-1:0] headMetricFlat
);

  localparam int FILL_COUNT = (DEPTH - 1) * NUM_STREAMS;
  localparam int CNT_W      = $clog2(FILL_COUNT + 1);

  logic [CNT_W-1:0]      seen;
  logic [NUM_STATES-1:0] msbs;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (inValid && seen != CNT_W'(FILL_COUNT)) seen <= seen + 1'b1;
  end

  always_comb begin
    for (int s = 0; s < NUM_STATES; s++) begin
      msbs[s] = headMetricFlat[s*METRIC_W + METRIC_W - 1];
    end
  end

  // R1: reset forces the output strobe low.
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !outValid);

  // R6: no output during the fill.
  a_r6_fill_wait: assert property (@(posedge clk) disable iff (rst)
    (inValid && seen != CNT_W'(FILL_COUNT)) |=> !outValid);

  // R5: once primed, every accepted symbol yields an output.
  a_r5_full_rate: assert property (@(posedge clk) disable iff (rst)
    (inValid && seen == CNT_W'(FILL_COUNT)) |=> outValid);

  // R7: an idle input cycle produces no output.
  a_r7_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R3: stored metrics never sit all in the upper half of the range.
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    !(&msbs));

endmodule

bind viterbiInterleaved vitChecker #(
  .NUM_STREAMS (NUM_STREAMS),
  .DEPTH       (DEPTH),
  .METRIC_W    (METRIC_W),
  .NUM_STATES  (vitPkg::NUM_STATES)
) uChecker (
  .clk            (clk),
  .rst            (rst),
  .inValid        (inValid),
  .outValid       (outValid),
  .headMetricFlat (headMetricFlat)
);

// File: tb/tb_viterbiInterleaved.sv
module tb_viterbiInterleaved;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_STREAMS = 4;
  localparam int DEPTH = 15;
  localparam int FILL = (DEPTH - 1) * NUM_STREAMS;
  localparam int RUN_LEN = 200;
  localparam int MAX_INFO = 400;

  // [27:20] expected outputs, [19] inject flips, [18] idle gaps,
  // [17:16] bit pattern (0 pseudo-random, 1 fixed per stream), [15:0] seed
  localparam logic [27:0] SCENARIOS [4] = '{
    {8'd144, 1'b0, 1'b0, 2'd0, 16'hACE1},
    {8'd144, 1'b0, 1'b0, 2'd1, 16'h0001},
    {8'd144, 1'b0, 1'b1, 2'd0, 16'h1D2C},
    {8'd144, 1'b1, 1'b1, 2'd0, 16'hBEEF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [1:0] inSym = 2'b00;
  logic outValid;
  logic outBit;

  int checks = 0;
  int errors = 0;
  logic infoBits [MAX_INFO];
  logic [1:0] encState [NUM_STREAMS];
  logic [15:0] lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  viterbiInterleaved #(.NUM_STREAMS(NUM_STREAMS), .DEPTH(DEPTH), .METRIC_W(6)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSym(inSym),
    .outValid(outValid), .outBit(outBit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic lfsrStep();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic fillInfo(input logic [15:0] seed, input logic [1:0] mode, input int count);
    lfsr = seed;
    for (int n = 0; n < count; n++) begin
      int s = n % NUM_STREAMS;
      int k = n / NUM_STREAMS;
      if (mode == 2'd1) begin
        case (s)
          0: infoBits[n] = 1'b1;
          1: infoBits[n] = 1'b0;
          2: infoBits[n] = k[0];
          default: infoBits[n] = (k % 3 == 0);
        endcase
      end else begin
        infoBits[n] = lfsrStep();
      end
    end
  endtask

  function automatic logic [1:0] encode(input int n);
    int s = n % NUM_STREAMS;
    logic u = infoBits[n];
    logic [1:0] st = encState[s];
    logic c0 = u ^ st[1] ^ st[0];
    logic c1 = u ^ st[0];
    encState[s] = {u, st[1]};
    return {c1, c0};
  endfunction

  task automatic clearEncoders();
    for (int s = 0; s < NUM_STREAMS; s++) encState[s] = 2'b00;
  endtask

  task automatic doReset();
    rst = 1'b1;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(outValid == 1'b0, "R1 reset", int'(outValid), 0);
  endtask

  task automatic sendSym(input logic [1:0] sym);
    inValid = 1'b1;
    inSym = sym;
    @(negedge clk);
  endtask

  task automatic idleCycle();
    inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R7 idle", int'(outValid), 0);
  endtask

  task automatic runScenario(input logic [27:0] entry);
    int outCount = 0;
    string tag = entry[19] ? "R8 corrected" : (entry[17:16] == 2'd1 ? "R4 streams" : "R2 decode");
    doReset();
    fillInfo(entry[15:0], entry[17:16], RUN_LEN);
    clearEncoders();
    for (int n = 0; n < RUN_LEN; n++) begin
      logic [1:0] sym = encode(n);
      if (entry[19] && (n % 37 == 5)) sym = sym ^ ((n / 37) % 2 == 0 ? 2'b01 : 2'b10);
      if (entry[18] && (n % 7 == 3)) idleCycle();
      sendSym(sym);
      if (n < FILL) check(outValid == 1'b0, "R6 fill", int'(outValid), 0);
      else check(outValid == 1'b1, "R5 rate", int'(outValid), 1);
      if (outValid && n >= FILL) begin
        outCount++;
        check(outBit == infoBits[n - FILL], tag, int'(outBit), int'(infoBits[n - FILL]));
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    check(outCount == int'(entry[27:20]), "R5 count", outCount, int'(entry[27:20]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    foreach (SCENARIOS[i]) runScenario(SCENARIOS[i]);

    // R1: reset during traffic restarts the fill.
    doReset();
    fillInfo(16'h5A5A, 2'd0, 100);
    clearEncoders();
    for (int n = 0; n < 100; n++) sendSym(encode(n));
    doReset();
    fillInfo(16'h3C3C, 2'd0, FILL + 8);
    clearEncoders();
    for (int n = 0; n < FILL + 8; n++) begin
      sendSym(encode(n));
      if (n < FILL) check(outValid == 1'b0, "R1 refill", int'(outValid), 0);
      else check(outValid && outBit == infoBits[n - FILL], "R1 restart decode",
                 int'(outBit), int'(infoBits[n - FILL]));
    end

    // R3: long random input pushes metrics through normalization, then clean data.
    doReset();
    lfsr = 16'h7777;
    for (int n = 0; n < 800; n++) begin
      logic b0 = lfsrStep();
      logic b1 = lfsrStep();
      sendSym({b1, b0});
    end
    fillInfo(16'h4321, 2'd0, MAX_INFO);
    clearEncoders();
    for (int n = 0; n < MAX_INFO; n++) begin
      sendSym(encode(n));
      if (n >= FILL + 40)
        check(outValid && outBit == infoBits[n - FILL], "R3 after noise",
              int'(outBit), int'(infoBits[n - FILL]));
    end
    inValid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule